// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block sits behind an infrared demodulator and converts its raw line into a stream of run-length bytes for a downstream FIFO. The line is sampled once per slow sample tick, which is derived from the block clock by a fixed divide (64 by default). Consecutive samples at one level form a run. When the level changes, the block emits one byte. Its top bit is the run level (1 = pulse, 0 = space) and its low seven bits are the run length in ticks. The line passes through a two-flop synchronizer, and an optional inversion flips the line before the level decision. Short excursions below a programmable noise threshold are absorbed into the run around them.

When the line has been at space for a programmable number of consecutive samples, the block closes the packet. It emits the space run accumulated so far and raises a one-cycle packet-end pulse. It then stays silent until a new pulse run is confirmed. Software-visible registers, the FIFO and protocol decoding live elsewhere. This block only needs its enables and thresholds held steady while it runs.

Top module: `ir_runlen_sampler`

## Requirements
- R1: The line is sampled once every DIV clock cycles (DIV = 64 by default). While the block is disabled the divider is held at zero, so the first sample after enabling is taken on the DIV-th clock edge.
- R2: Each output byte carries the run level in bit 7 (1 = pulse, 0 = space) and the run length in ticks in bits 6:0. The length of an emitted byte is never zero.
- R3: When `pol_inv` is 1, a high line is treated as space and a low line as pulse. An inverted waveform then produces the same byte stream as the plain waveform with `pol_inv` at 0.
- R4: A run of the opposite level shorter than `noise_thr` ticks is not emitted. Its ticks are added to the length of the run it interrupts. A `noise_thr` of 0 or 1 makes every change take effect at once.
- R5: A run longer than 127 ticks is split. The block emits a byte of length 127 each time 127 ticks have built up and keeps counting the same level. The remainder is emitted when the level changes.
- R6: Once `idle_thr` consecutive space samples have been taken (`idle_thr` nonzero), the block emits the current space run as a byte and asserts `pkt_end` in the same cycle as that byte.
- R7: From reset, and after a packet end, no byte is emitted while the line stays at space. The next byte describes the first confirmed pulse run.
- R8: The block samples only while both `glb_en` and `rx_en` are 1. While either is 0, no byte and no packet end is produced and the run state returns to its reset state.
- R9: `byte_vld` and `pkt_end` are single-cycle pulses. At most one byte is produced per sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable; also restarts the sample divider |
| pol_inv | input | 1 | Invert the sense of the infrared line |
| noise_thr | input | 6 | Minimum run length in ticks that counts as a level change |
| idle_thr | input | 8 | Consecutive space ticks that end a packet; 0 disables |
| ir_in | input | 1 | Raw demodulated infrared line (asynchronous) |
| byte_vld | output | 1 | One-cycle strobe: `byte_dat` holds a new run byte |
| byte_dat | output | 8 | Run byte: bit 7 level, bits 6:0 length in ticks |
| pkt_end | output | 1 | One-cycle packet-end pulse |

## Verification
On every cycle, the assertions check the following. Sample ticks and output strobes never last two cycles. Disabling the block silences its outputs on the next edge. An emitted byte never has a zero length. A packet end always comes with a space byte. The bench scenarios have to show the stream-level behaviour: the exact byte values for plain and inverted waveforms, the merging of glitches below the noise threshold, the split at 127 ticks, the silence after a packet end, and the divider restart.

// File: rtl/irs_pkg.sv
package irs_pkg;
  localparam int LEN_W   = 7;
  localparam int LEN_MAX = (1 << LEN_W) - 1;

  typedef struct packed {
    logic             lvl;
    logic [LEN_W-1:0] len;
  } run_byte_t;

  localparam logic LVL_SPACE = 1'b0;
  localparam logic LVL_PULSE = 1'b1;
endpackage

// File: rtl/irs_line_sync.sv
module irs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pol_inv,
  input  logic ir_in,
  output logic lvl
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= ir_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], ir_in};
      end
    end
  endgenerate

  assign lvl = sh_q[STAGES-1] ^ pol_inv;
endmodule

// File: rtl/irs_tick_gen.sv
module irs_tick_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_en)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run_en && (cnt_q == LAST);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick) else $error("tick lasted two cycles");

  assert_div_held_R1: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (cnt_q == '0)) else $error("divider not held while disabled");
endmodule

// File: rtl/irs_run_tracker.sv
module irs_run_tracker
  import irs_pkg::*;
#(
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic               tick,
  input  logic               lvl,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  output logic               byte_vld,
  output run_byte_t          byte_dat,
  output logic               pkt_end
);
  localparam int TW = LEN_W + 2;
  localparam logic [TW-1:0] TMAX = TW'(LEN_MAX);
  localparam logic [IDLE_W-1:0] IDLE_SAT = '1;

  logic               cur_q, cur_n;
  logic [LEN_W-1:0]   len_q, len_n;
  logic [NOISE_W-1:0] pend_q, pend_n;
  logic [IDLE_W-1:0]  idle_q, idle_n;
  logic               quiet_q, quiet_n;

  logic               emit_n, pend_n_end;
  run_byte_t          emit_dat;

  logic [NOISE_W:0]   pend_inc;
  logic [TW-1:0]      total;

  assign pend_inc = {1'b0, pend_q} + (NOISE_W+1)'(1);
  assign total    = TW'(len_q) + TW'(pend_q) + TW'(1);

  always_comb begin
    cur_n      = cur_q;
    len_n      = len_q;
    pend_n     = pend_q;
    idle_n     = idle_q;
    quiet_n    = quiet_q;
    emit_n     = 1'b0;
    pend_n_end = 1'b0;
    emit_dat   = '0;
    if (tick) begin
      if (lvl) idle_n = '0;
      else if (idle_q != IDLE_SAT) idle_n = idle_q + 1'b1;

      if (lvl != cur_q) begin
        if (pend_inc >= {1'b0, noise_thr}) begin
          // confirmed level change: close the old run
          if (!quiet_q && len_q != '0) begin
            emit_n   = 1'b1;
            emit_dat = '{lvl: cur_q, len: len_q};
          end
          cur_n   = lvl;
          len_n   = LEN_W'(pend_inc);
          pend_n  = '0;
          quiet_n = 1'b0;
        end else begin
          pend_n = pend_inc[NOISE_W-1:0];
        end
      end else if (quiet_q) begin
        len_n  = '0;
        pend_n = '0;
      end else begin
        pend_n = '0;
        if (total >= TMAX) begin
          emit_n   = 1'b1;
          emit_dat = '{lvl: cur_q, len: LEN_W'(LEN_MAX)};
          len_n    = LEN_W'(total - TMAX);
        end else if (cur_q == LVL_SPACE && idle_thr != '0 && idle_n >= idle_thr) begin
          emit_n     = 1'b1;
          emit_dat   = '{lvl: LVL_SPACE, len: LEN_W'(total)};
          pend_n_end = 1'b1;
          quiet_n    = 1'b1;
          len_n      = '0;
        end else begin
          len_n = LEN_W'(total);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cur_q    <= LVL_SPACE;
      len_q    <= '0;
      pend_q   <= '0;
      idle_q   <= '0;
      quiet_q  <= 1'b1;
      byte_vld <= 1'b0;
      byte_dat <= '0;
      pkt_end  <= 1'b0;
    end else begin
      cur_q    <= cur_n;
      len_q    <= len_n;
      pend_q   <= pend_n;
      idle_q   <= idle_n;
      quiet_q  <= quiet_n;
      byte_vld <= emit_n;
      pkt_end  <= pend_n_end;
      if (emit_n) byte_dat <= emit_dat;
    end
  end

  assert_byte_single_R9: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld) else $error("byte strobe lasted two cycles");

  assert_pkt_single_R9: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> !pkt_end) else $error("packet end lasted two cycles");

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> (byte_dat.len != '0)) else $error("zero-length byte");

  assert_pkt_with_space_R6: assert property (@(posedge clk) disable iff (rst)
    pkt_end |-> (byte_vld && byte_dat.lvl == LVL_SPACE)) else $error("packet end without space byte");

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!byte_vld && !pkt_end)) else $error("output while disabled");

  assert_silent_in_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (quiet_q && !lvl) |=> !byte_vld) else $error("byte while idle after packet end");
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
  import irs_pkg::*;
#(
  parameter int DIV         = 64,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic               rx_en,
  input  logic               pol_inv,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_in,
  output logic               byte_vld,
  output logic [LEN_W:0]     byte_dat,
  output logic               pkt_end
);
  logic      run_en;
  logic      tick;
  logic      lvl;
  run_byte_t rb;

  assign run_en = glb_en & rx_en;

  irs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pol_inv(pol_inv), .ir_in(ir_in), .lvl(lvl)
  );

  irs_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick)
  );

  irs_run_tracker #(.NOISE_W(NOISE_W), .IDLE_W(IDLE_W)) u_track (
    .clk(clk), .rst(rst), .run_en(run_en), .tick(tick), .lvl(lvl),
    .noise_thr(noise_thr), .idle_thr(idle_thr),
    .byte_vld(byte_vld), .byte_dat(rb), .pkt_end(pkt_end)
  );

  assign byte_dat = rb;
endmodule

// File: tb/tb_ir_runlen_sampler.sv
module tb_ir_runlen_sampler;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       glb_en = 1'b0, rx_en = 1'b0, pol_inv = 1'b0, ir_in = 1'b0;
  logic [5:0] noise_thr = 6'd1;
  logic [7:0] idle_thr = 8'd20;
  logic       byte_vld, pkt_end;
  logic [7:0] byte_dat;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  logic [7:0] got [64];
  int gn = 0, pkts = 0, pkt_idx = -1, pkt_alone = 0, dbl = 0;
  logic prev_vld = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_runlen_sampler dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .rx_en(rx_en), .pol_inv(pol_inv),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .pkt_end(pkt_end)
  );

  always @(negedge clk) begin
    if (byte_vld && prev_vld) dbl++;
    prev_vld = byte_vld;
    if (byte_vld) begin
      if (gn < 64) got[gn] = byte_dat;
      gn++;
    end
    if (pkt_end) begin
      pkts++;
      pkt_idx = gn;
      if (!byte_vld) pkt_alone++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic clear_log();
    gn = 0; pkts = 0; pkt_idx = -1; pkt_alone = 0;
  endtask

  // level is the logical level (1 = pulse); pol_inv decides the wire value
  task automatic drive(input logic level, input int ticks);
    ir_in = level ^ pol_inv;
    repeat (ticks * DIV) @(negedge clk);
  endtask

  task automatic start(input logic inv, input logic [5:0] nthr, input logic [7:0] ithr);
    glb_en = 1'b0; rx_en = 1'b1;
    pol_inv = inv; noise_thr = nthr; idle_thr = ithr;
    ir_in = inv;
    repeat (5) @(negedge clk);
    clear_log();
    glb_en = 1'b1;
    drive(1'b0, 6);
  endtask

  task automatic expect_bytes(input string req, input logic [7:0] exp [], input int n);
    chk(gn == n, {req, " byte count"}, gn, n);
    for (int i = 0; i < n && i < gn; i++)
      chk(got[i] == exp[i], req, got[i], exp[i]);
  endtask

  // R2 R6 R7: basic packet, plain polarity
  task automatic t_basic();
    logic [7:0] e [] = '{8'h89, 8'h04, 8'h85, 8'h14};
    start(1'b0, 6'd1, 8'd20);
    drive(1'b1, 9); drive(1'b0, 4); drive(1'b1, 5); drive(1'b0, 30);
    expect_bytes("R2", e, 4);
    chk(pkts == 1, "R6 packet count", pkts, 1);
    chk(pkt_idx == 4, "R6 packet end with last byte", pkt_idx, 4);
    chk(pkt_alone == 0, "R6 packet end without byte", pkt_alone, 0);
    drive(1'b0, 25);
    chk(gn == 4, "R7 silent after packet end", gn, 4);
    chk(pkts == 1, "R7 no second packet end", pkts, 1);
  endtask

  // R3: inverted wire, same logical waveform
  task automatic t_invert();
    logic [7:0] e [] = '{8'h89, 8'h04, 8'h85, 8'h14};
    start(1'b1, 6'd1, 8'd20);
    drive(1'b1, 9); drive(1'b0, 4); drive(1'b1, 5); drive(1'b0, 22);
    expect_bytes("R3", e, 4);
    chk(pkts == 1, "R3 packet end", pkts, 1);
    pol_inv = 1'b0;
  endtask

  // R4: glitch of 2 inside pulse with noise threshold 3
  task automatic t_noise();
    logic [7:0] e [] = '{8'h92, 8'h14};
    start(1'b0, 6'd3, 8'd20);
    drive(1'b1, 10); drive(1'b0, 2); drive(1'b1, 6); drive(1'b0, 25);
    expect_bytes("R4", e, 2);
    chk(pkts == 1, "R4 packet end", pkts, 1);
  endtask

  // R5: 300-tick pulse splits into 127 + 127 + 46
  task automatic t_split();
    logic [7:0] e [] = '{8'hFF, 8'hFF, 8'hAE, 8'h14};
    start(1'b0, 6'd1, 8'd20);
    drive(1'b1, 300); drive(1'b0, 22);
    expect_bytes("R5", e, 4);
  endtask

  // R8: global enable off blocks everything
  task automatic t_disabled();
    glb_en = 1'b0; rx_en = 1'b1; noise_thr = 6'd1; idle_thr = 8'd20;
    repeat (3) @(negedge clk);
    clear_log();
    drive(1'b1, 8); drive(1'b0, 4); drive(1'b1, 8); drive(1'b0, 25);
    chk(gn == 0, "R8 no bytes while disabled", gn, 0);
    chk(pkts == 0, "R8 no packet end while disabled", pkts, 0);
  endtask

  // R1: divider restarts with rx_en; first sample on DIV-th edge
  task automatic t_prescale();
    logic [7:0] e [] = '{8'h85, 8'h14};
    glb_en = 1'b1; rx_en = 1'b0; noise_thr = 6'd1; idle_thr = 8'd20;
    ir_in = 1'b1;
    repeat (37) @(negedge clk);
    clear_log();
    rx_en = 1'b1;
    repeat (5 * DIV + DIV/2) @(negedge clk);
    ir_in = 1'b0;
    repeat (22 * DIV) @(negedge clk);
    expect_bytes("R1", e, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(byte_vld == 1'b0, "R9 reset byte_vld", byte_vld, 0);
    chk(pkt_end == 1'b0, "R9 reset pkt_end", pkt_end, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_basic();
    t_invert();
    t_noise();
    t_split();
    t_disabled();
    t_prescale();
    chk(dbl == 0, "R9 back-to-back strobes", dbl, 0);
    done = 1'b1;
    report();
  end
endmodule